// File: doc/BRIEF.md
# Synchronous FIFO with Fall-Through Mode and Replay

A single-clock FIFO for 18-bit words. Its read side has two behaviours, chosen while the active-low master reset is held. In standard mode a read request loads the next word into the output register, and the two status outputs mean "empty" and "full". In fall-through mode the oldest stored word is already on the output without a request, and the same two status outputs mean "output ready" and "input ready". A half-full output is driven in both modes.

A mark strobe saves the current head of the queue. A later retransmit strobe rewinds the head to the saved position, so every word from that point onward can be read again. While a mark is held, the FIFO keeps those words: it reports full once the span from the mark to the write position fills the storage. Memory accesses happen only while the access-enable input is high.

Top module: `fifo_rt`

## Requirements
- R1: After master reset the queue is empty, `rd_data` is all zeros and `half_full` is 0. In standard mode `stat_out`=1 and `stat_in`=0. In fall-through mode `stat_out`=0 and `stat_in`=1.
- R2: `fwft_sel` is sampled on every clock edge while `rst_n` is low (1 = fall-through, 0 = standard). The mode then holds until the next reset, whatever `fwft_sel` does.
- R3: In standard mode, a read of a non-empty queue places the oldest word on `rd_data` in the cycle after the request. Words leave in write order, and `rd_data` holds its value between reads.
- R4: In standard mode, `stat_out` is 1 exactly when no words are stored, and `stat_in` is 1 exactly when the FIFO is full.
- R5: In fall-through mode, the oldest word is on `rd_data` with `stat_out` (output ready) at 1 in the cycle after the write that fills an empty FIFO, with no read request. A read while ready presents the next word one cycle later. `stat_in` (input ready) is the inverse of full.
- R6: `half_full` is 1 exactly when more than DEPTH/2 unread words are stored.
- R7: A write while full and a read while empty are dropped. Stored contents, flags and `rd_data` are left unchanged.
- R8: When a read and a write fall in the same cycle, an empty FIFO accepts the write and drops the read. A full FIFO performs the read and drops the write.
- R9: While `mem_acc_en` is 0, `wr_en` and `rd_en` have no effect.
- R10: `mark` saves the current head position, which in fall-through mode is the word shown on `rd_data`. A read in the same cycle is taken after the mark.
- R11: Once a mark is held, `rexmit` rewinds the head to the marked word and sets the count to the words from the mark to the write position. The mark stays armed for later replays. `rexmit` wins over `mark` in the same cycle, and any read in that cycle is dropped. `rexmit` with no mark held is ignored.
- R12: While a mark is held, full is reported once the words from the mark to the write position reach DEPTH, and further writes are blocked. A new mark at the current head releases the space behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| fwft_sel | input | 1 | Mode select, sampled during reset (1 = fall-through) |
| mem_acc_en | input | 1 | Enables memory writes and reads |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | W | Output register |
| mark | input | 1 | Save the head position |
| rexmit | input | 1 | Rewind the head to the saved position |
| stat_out | output | 1 | Empty (standard) / output ready (fall-through) |
| stat_in | output | 1 | Full (standard) / input ready (fall-through) |
| half_full | output | 1 | More than DEPTH/2 words stored |

## Verification
Reads and writes can collide in the same cycle, and so can a retransmit and a write. A write in the cycle of a rewind must land both in the replayed stream and in the retained span. The bench drives a read and a write together at both the empty and the full boundary, in each mode. It also rewinds in the same cycle as a write, and fires mark and retransmit together. Each cycle is judged against a bench queue model that keeps a readable queue and a retained copy taken at the mark. Every flag and the output word are compared with that model.

// File: rtl/fifo_rt_pkg.sv
// Shared types for the replay FIFO.
package fifo_rt_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/fifo_rt_store.sv
// Storage array: one synchronous write port and one combinational read port.
// Assumes the controller never writes a slot that is still retained.
// The array has no reset; the output register masks its undefined contents.
module fifo_rt_store #(
    parameter int W     = 18,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Commit an accepted write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_rt_ctrl.sv
// Pointer and count controller. It tracks the head (read) pointer, the write
// pointer, the number of unread words, and an optional mark with the span of
// words retained from the mark to the write pointer.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
module fifo_rt_ctrl #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          mark_req,
    input  logic          rexmit_req,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] rd_ptr_nxt,
    output logic          cnt_nxt_nz,
    output logic          empty,
    output logic          full,
    output logic          half_full
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    logic [CW-1:0] cnt, cnt_nxt;
    logic [CW-1:0] span, span_nxt;
    logic [AW-1:0] mark_ptr;
    logic          marked;
    logic          rex_go;

    assign empty     = (cnt == '0);
    assign full      = marked ? (span == FULL_CNT) : (cnt == FULL_CNT);
    assign half_full = (cnt > HALF_CNT);

    assign rex_go = rexmit_req & marked;
    assign wr_go  = wr_req & acc_en & ~full;
    assign rd_go  = rd_req & acc_en & ~empty & ~rex_go;

    // Next head position: rewind, advance or hold.
    always_comb begin
        if (rex_go)     rd_ptr_nxt = mark_ptr;
        else if (rd_go) rd_ptr_nxt = rd_ptr + AW'(1);
        else            rd_ptr_nxt = rd_ptr;
    end

    // Next unread count and retained span.
    always_comb begin
        if (rex_go) begin
            cnt_nxt  = span + CW'(wr_go);
            span_nxt = span + CW'(wr_go);
        end else begin
            cnt_nxt = cnt + CW'(wr_go) - CW'(rd_go);
            if (mark_req)    span_nxt = cnt + CW'(wr_go);
            else if (marked) span_nxt = span + CW'(wr_go);
            else             span_nxt = span;
        end
    end

    assign cnt_nxt_nz = (cnt_nxt != '0);

    // Register the pointers, counts and mark state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            cnt      <= '0;
            span     <= '0;
            mark_ptr <= '0;
            marked   <= 1'b0;
        end else begin
            if (wr_go) wr_ptr <= wr_ptr + AW'(1);
            rd_ptr <= rd_ptr_nxt;
            cnt    <= cnt_nxt;
            span   <= span_nxt;
            if (mark_req && !rex_go) begin
                mark_ptr <= rd_ptr;
                marked   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fifo_rt_oreg.sv
// Output register. Standard mode loads the head word on an accepted read.
// Fall-through mode reloads the next head every cycle while words remain,
// and raises the ready flag together with the data.
// Assumes the write bypass is signalled when the next head is being written.
module fifo_rt_oreg
    import fifo_rt_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  rd_mode_e     mode,
    input  logic         rd_go,
    input  logic         cnt_nxt_nz,
    input  logic         byp,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] mem_q,
    output logic [W-1:0] q,
    output logic         ready
);
    // Load the output word and the ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            ready <= 1'b0;
        end else if (mode == MODE_FWFT) begin
            ready <= cnt_nxt_nz;
            if (cnt_nxt_nz) q <= byp ? wr_data : mem_q;
        end else begin
            ready <= 1'b0;
            if (rd_go) q <= mem_q;
        end
    end
endmodule

// File: rtl/fifo_rt.sv
// Top of the replay FIFO. It latches the read mode during reset and wires
// the controller, the storage and the output register together. The status
// outputs are steered by mode.
// Assumes a single clock and DEPTH a power of two.
module fifo_rt
    import fifo_rt_pkg::*;
#(
    parameter int W     = 18,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fwft_sel,
    input  logic         mem_acc_en,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    input  logic         mark,
    input  logic         rexmit,
    output logic         stat_out,
    output logic         stat_in,
    output logic         half_full
);
    localparam int AW = $clog2(DEPTH);

    rd_mode_e      mode_r;
    logic          wr_go, rd_go, cnt_nxt_nz, empty, full, ready, byp;
    logic [AW-1:0] wr_ptr, rd_ptr, rd_ptr_nxt, rd_addr;
    logic [W-1:0]  mem_q;

    // Capture the mode while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_r <= rd_mode_e'(fwft_sel);
    end

    fifo_rt_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (mem_acc_en),
        .wr_req     (wr_en),
        .rd_req     (rd_en),
        .mark_req   (mark),
        .rexmit_req (rexmit),
        .wr_go      (wr_go),
        .rd_go      (rd_go),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .rd_ptr_nxt (rd_ptr_nxt),
        .cnt_nxt_nz (cnt_nxt_nz),
        .empty      (empty),
        .full       (full),
        .half_full  (half_full)
    );

    assign rd_addr = (mode_r == MODE_FWFT) ? rd_ptr_nxt : rd_ptr;
    assign byp     = wr_go && (rd_addr == wr_ptr);

    fifo_rt_store #(.W(W), .DEPTH(DEPTH)) store_i (
        .clk   (clk),
        .we    (wr_go),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (mem_q)
    );

    fifo_rt_oreg #(.W(W)) oreg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_r),
        .rd_go      (rd_go),
        .cnt_nxt_nz (cnt_nxt_nz),
        .byp        (byp),
        .wr_data    (wr_data),
        .mem_q      (mem_q),
        .q          (rd_data),
        .ready      (ready)
    );

    assign stat_out = (mode_r == MODE_FWFT) ? ready  : empty;
    assign stat_in  = (mode_r == MODE_FWFT) ? ~full  : full;
endmodule

// File: rtl/fifo_rt_chk.sv
// Port-level checks for the replay FIFO, attached by bind.
module fifo_rt_chk
    import fifo_rt_pkg::*;
#(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input rd_mode_e     mode_q,
    input logic         wr_en,
    input logic         rd_en,
    input logic         mark,
    input logic         rexmit,
    input logic [W-1:0] rd_data,
    input logic         stat_out,
    input logic         stat_in,
    input logic         half_full
);
    logic rst_seen = 1'b0;

    // Note that a reset edge has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_seen <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_seen)
        $past(!rst_n) |-> (rd_data == '0 && !half_full));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));

    // R5
    fwft_ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FWFT && $rose(stat_out)) |-> ($past(wr_en) || $past(rexmit)));

    // R6
    half_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_full |-> ((mode_q == MODE_FWFT) ? stat_out : !stat_out));

    // R6
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en && !rexmit) |=> $stable(half_full));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STD && stat_in && wr_en && !rd_en && !mark && !rexmit) |=> stat_in);

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STD && stat_out && rd_en && !wr_en && !rexmit)
        |=> (stat_out && $stable(rd_data)));
endmodule

bind fifo_rt fifo_rt_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_r),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .mark      (mark),
    .rexmit    (rexmit),
    .rd_data   (rd_data),
    .stat_out  (stat_out),
    .stat_in   (stat_in),
    .half_full (half_full)
);

// File: tb/fifo_rt_tb_top.sv
`timescale 1ns/1ps
module fifo_rt_tb_top;
    localparam int W     = 18;
    localparam int DEPTH = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fwft_sel = 1'b0;
    logic         mem_acc_en = 1'b1;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic         mark = 1'b0;
    logic         rexmit = 1'b0;
    logic [W-1:0] rd_data;
    logic         stat_out, stat_in, half_full;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_n = 0;
    bit done = 1'b0;

    // Reference model: readable queue, retained copy from the mark.
    logic [W-1:0] q_m[$];
    logic [W-1:0] hist_m[$];
    bit           marked_m;
    bit           fwft_m;
    logic [W-1:0] last_m;

    fifo_rt #(.W(W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .fwft_sel(fwft_sel), .mem_acc_en(mem_acc_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .mark(mark), .rexmit(rexmit), .stat_out(stat_out), .stat_in(stat_in),
        .half_full(half_full)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 100000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all) act=%0d exp=<100000", cyc_n);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Compare every output with the model; called just after a negedge.
    task automatic check_all(input string tag);
        bit full_now;
        full_now = marked_m ? (hist_m.size() == DEPTH) : (q_m.size() == DEPTH);
        chk(tag, "stat_out", 32'(stat_out), fwft_m ? 32'(q_m.size() > 0) : 32'(q_m.size() == 0));
        chk(tag, "stat_in", 32'(stat_in), fwft_m ? 32'(!full_now) : 32'(full_now));
        chk(tag, "half_full", 32'(half_full), 32'(q_m.size() > DEPTH / 2));
        if (!fwft_m)             chk(tag, "rd_data", 32'(rd_data), 32'(last_m));
        else if (q_m.size() > 0) chk(tag, "rd_data", 32'(rd_data), 32'(q_m[0]));
    endtask

    // One clock of stimulus with model update and full comparison.
    task automatic step(input bit wr, input logic [W-1:0] wd, input bit rd,
                        input bit mk, input bit rx, input bit en, input string tag);
        bit full_m, do_wr, do_rd, rxg;
        full_m = marked_m ? (hist_m.size() == DEPTH) : (q_m.size() == DEPTH);
        rxg    = rx && marked_m;
        do_wr  = wr && en && !full_m;
        do_rd  = rd && en && (q_m.size() > 0) && !rxg;
        wr_en = wr; wr_data = wd; rd_en = rd; mark = mk; rexmit = rx; mem_acc_en = en;
        if (rxg) begin
            q_m = hist_m;
        end else begin
            if (mk) begin
                hist_m   = q_m;
                marked_m = 1'b1;
            end
            if (do_rd) last_m = q_m.pop_front();
        end
        if (do_wr) begin
            q_m.push_back(wd);
            if (marked_m) hist_m.push_back(wd);
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; mark = 1'b0; rexmit = 1'b0; mem_acc_en = 1'b1;
        check_all(tag);
    endtask

    task automatic do_reset(input bit fwft);
        @(negedge clk);
        rst_n = 1'b0;
        fwft_sel = fwft;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        q_m.delete();
        hist_m.delete();
        marked_m = 1'b0;
        fwft_m   = fwft;
        last_m   = '0;
    endtask

    // R1: state right after reset in both modes.
    task automatic t_reset();
        do_reset(1'b0);
        chk("R1", "std rd_data", 32'(rd_data), 32'h0);
        chk("R1", "std empty", 32'(stat_out), 32'h1);
        chk("R1", "std full", 32'(stat_in), 32'h0);
        chk("R1", "std half", 32'(half_full), 32'h0);
        do_reset(1'b1);
        chk("R1", "fwft rd_data", 32'(rd_data), 32'h0);
        chk("R1", "fwft ready", 32'(stat_out), 32'h0);
        chk("R1", "fwft in_ready", 32'(stat_in), 32'h1);
    endtask

    // R2: mode is held after reset even if fwft_sel changes.
    task automatic t_mode_hold();
        do_reset(1'b1);
        fwft_sel = 1'b0;
        step(1, 18'h2A5A5, 0, 0, 0, 1, "R2");
        chk("R2", "still fall-through", 32'(stat_out), 32'h1);
        fwft_sel = 1'b1;
        do_reset(1'b0);
        fwft_sel = 1'b1;
        step(1, 18'h01234, 0, 0, 0, 1, "R2");
        chk("R2", "still standard", 32'(rd_data), 32'h0);
    endtask

    // R3 R4 R6 R7: fill past full, then drain past empty in standard mode.
    task automatic t_std_fill_drain();
        do_reset(1'b0);
        for (int i = 0; i < DEPTH + 2; i++) step(1, 18'(32'h100 + i), 0, 0, 0, 1, "R4/R6/R7");
        chk("R4", "full at DEPTH", 32'(stat_in), 32'h1);
        for (int i = 0; i < DEPTH + 2; i++) step(0, '0, 1, 0, 0, 1, "R3/R6/R7");
        chk("R7", "last word held", 32'(rd_data), 32'(18'h100 + DEPTH - 1));
    endtask

    // R8: same-cycle read and write at both boundaries, both modes.
    task automatic t_collide(input bit fwft);
        do_reset(fwft);
        step(1, 18'h3C3C3, 1, 0, 0, 1, "R8");
        step(0, '0, 1, 0, 0, 1, "R8");
        for (int i = 0; i < DEPTH; i++) step(1, 18'(32'h200 + i), 0, 0, 0, 1, "R8");
        step(1, 18'h3FFFF, 1, 0, 0, 1, "R8");
        for (int i = 0; i < DEPTH; i++) step(0, '0, 1, 0, 0, 1, "R8");
    endtask

    // R9: access enable low makes requests inert.
    task automatic t_acc_gate();
        do_reset(1'b0);
        step(1, 18'h00011, 0, 0, 0, 1, "R9");
        step(1, 18'h00022, 0, 0, 0, 1, "R9");
        step(1, 18'h00033, 1, 0, 0, 0, "R9");
        step(0, '0, 1, 0, 0, 0, "R9");
        step(0, '0, 1, 0, 0, 1, "R9");
        chk("R9", "first word after gated cycles", 32'(rd_data), 32'h11);
        step(0, '0, 1, 0, 0, 1, "R9");
        chk("R9", "gated write absent", 32'(stat_out), 32'h1);
    endtask

    // R5: fall-through presentation and advance.
    task automatic t_fwft();
        do_reset(1'b1);
        step(1, 18'h0ABCD, 0, 0, 0, 1, "R5");
        chk("R5", "word fell through", 32'(rd_data), 32'h0ABCD);
        step(1, 18'h0BEEF, 0, 0, 0, 1, "R5");
        step(0, '0, 1, 0, 0, 1, "R5");
        chk("R5", "next word after read", 32'(rd_data), 32'h0BEEF);
        step(0, '0, 1, 0, 0, 1, "R5");
        chk("R5", "ready low when drained", 32'(stat_out), 32'h0);
    endtask

    // R10 R11: mark, consume, rewind and replay.
    task automatic t_replay(input bit fwft);
        do_reset(fwft);
        step(0, '0, 0, 0, 1, 1, "R11");
        for (int i = 0; i < 4; i++) step(1, 18'(32'h300 + i), 0, 0, 0, 1, "R10");
        step(0, '0, 1, 0, 0, 1, "R10");
        step(0, '0, 1, 1, 0, 1, "R10");
        step(0, '0, 1, 0, 0, 1, "R10");
        step(1, 18'h00400, 0, 0, 1, 1, "R11");
        if (!fwft) step(0, '0, 1, 0, 0, 1, "R10");
        chk("R10", "replay starts at marked word", 32'(rd_data), 32'h301);
        while (q_m.size() > 0) step(0, '0, 1, 0, 0, 1, "R11");
        step(0, '0, 0, 1, 1, 1, "R11");
        chk("R11", "rewind wins over mark", 32'(stat_out), fwft ? 32'h1 : 32'h0);
        step(0, '0, 1, 0, 0, 1, "R11");
        for (int i = 0; i < 3; i++) step(0, '0, 1, 0, 0, 1, "R11");
    endtask

    // R12: retention blocks writes until re-marked.
    task automatic t_retain();
        do_reset(1'b0);
        step(1, 18'h00501, 0, 0, 0, 1, "R12");
        step(1, 18'h00502, 0, 0, 0, 1, "R12");
        step(0, '0, 0, 1, 0, 1, "R12");
        step(0, '0, 1, 0, 0, 1, "R12");
        step(0, '0, 1, 0, 0, 1, "R12");
        for (int i = 0; i < DEPTH - 1; i++) step(1, 18'(32'h600 + i), 0, 0, 0, 1, "R12");
        chk("R12", "full from retained span", 32'(stat_in), 32'h1);
        step(0, '0, 0, 1, 0, 1, "R12");
        chk("R12", "re-mark frees space", 32'(stat_in), 32'h0);
        step(1, 18'h00777, 0, 0, 0, 1, "R12");
    endtask

    initial begin
        t_reset();
        t_mode_hold();
        t_std_fill_drain();
        t_collide(1'b0);
        t_collide(1'b1);
        t_acc_gate();
        t_fwft();
        t_replay(1'b0);
        t_replay(1'b1);
        t_retain();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule